// File: doc/BRIEF.md
# CDR Lock and Mute Supervisor

This block is the digital supervisor for one clock-and-data-recovery channel. It runs on the local reference clock. It decides whether the recovery loop trains on that reference or follows the incoming line data. It checks the recovered clock by adding up recovered-clock ticks over a fixed window of reference cycles. It reports loss of lock, and it forces the receive data to zero while the signal is absent.

Each reference cycle, a counter in the recovered domain delivers the number of recovered ticks seen in that cycle on `rec_inc_i`. The window total is compared against an expected count. That count depends on the channel's own line-rate select and on the shared reference-frequency select, so several channels can run at different rates from one reference. The external signal-detect input passes through a two-flop synchronizer. The internal data-loss flag can be masked.

Top module: `cdr_lock_supervisor`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `loop_sel_o` is 0 (loop on the reference), `lol_o` is 1 and `data_o` is 0.
- R2: A window is 2^WIN_LOG2 consecutive clock cycles, counted from reset release or power-down release. The measured value is the sum of `rec_inc_i` over the window. The expected value is round(2^WIN_LOG2 × rate_units / ref_units). rate_units is 96 for `rate_sel_i`=0 (622.08 Mb/s), 24 for 1 (155.52 Mb/s), and 8 for 2 or 3 (51.84 Mb/s). ref_units is 3 for `ref_sel_i`=0 (19.44 MHz) and 12 for 1 (77.76 MHz).
- R3: The block leaves the reference only at the last edge of the LOCK_WIN-th consecutive in-tolerance window (default 2), and only if loss of signal is absent. An out-of-tolerance window restarts that count.
- R4: While tracking, an out-of-tolerance window sets `loop_sel_o` to 0 and `lol_o` to 1 at that window's last edge.
- R5: Loss of signal is `sd_i` low (seen 2 edges later, after synchronization) or `dlos_i` high with `dlos_dis_i` low (seen in the same cycle). While it lasts, `data_o` is 0; otherwise `data_o` follows `data_i`.
- R6: Loss of signal while tracking returns the loop to the reference on the next edge.
- R7: If the window count is complete while loss of signal holds, the block stays on the reference and keeps the count. Once loss of signal clears, the next in-tolerance window returns it to tracking.
- R8: With `dlos_dis_i` high, `dlos_i` has no effect on `data_o` or `loop_sel_o`.
- R9: `lol_o` is 1 exactly when `loop_sel_o` is 0, so the recovered clock comes from the reference during loss of lock or loss of signal.
- R10: `pd_i` high forces `data_o` to 0 in the same cycle. From the next edge it gives `loop_sel_o`=0 and `lol_o`=1, and it clears the window and the good-window count.
- R11: A window is in tolerance when |measured − expected| ≤ floor(expected/2000), both bounds included. This holds for every rate and reference combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rec_inc_i | input | INC_W | Recovered-clock ticks counted during this reference cycle |
| rate_sel_i | input | 2 | Line rate: 0=622.08, 1=155.52, 2/3=51.84 Mb/s |
| ref_sel_i | input | 1 | Reference: 0=19.44 MHz, 1=77.76 MHz |
| sd_i | input | 1 | Asynchronous external signal detect, high when light is present |
| dlos_i | input | 1 | Internal data-loss flag |
| dlos_dis_i | input | 1 | Mask for `dlos_i` |
| pd_i | input | 1 | Channel power-down |
| data_i | input | 1 | Recovered receive data |
| loop_sel_o | output | 1 | 1 = loop tracks line data, 0 = loop on reference |
| lol_o | output | 1 | Loss of lock |
| data_o | output | 1 | Receive data, squelched during loss of signal |

## Verification
The window verdict lands at the edge that closes the window. The bench therefore keeps its own phase counter and checks the loop select one time unit after that edge. A falling `sd_i` mutes `data_o` after exactly two edges and moves the loop after three. The bench checks at each of those edges, so an extra or missing synchronizer stage is caught. The data-loss flag and power-down act on `data_o` within the same cycle, so those checks follow a short settle delay after the input changes. Their effect on the loop select is checked after one more edge.

// File: rtl/cdr_sup_pkg.sv
package cdr_sup_pkg;

  typedef enum logic {ST_REF = 1'b0, ST_TRACK = 1'b1} cdr_state_e;

  // rounded expected tick count per window; units of 6.48 MHz
  function automatic longint expected_count(int win_log2, int rate, int refsel);
    longint win, ru, rf;
    win = longint'(1) << win_log2;
    case (rate)
      0:       ru = 96;
      1:       ru = 24;
      default: ru = 8;
    endcase
    rf = (refsel != 0) ? 12 : 3;
    return (win * ru + rf / 2) / rf;
  endfunction

endpackage

// File: rtl/cdr_sync2.sv
module cdr_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cdr_freq_meter.sv
module cdr_freq_meter #(
  parameter int unsigned WIN_LOG2 = 15,
  parameter int unsigned INC_W    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [1:0]       rate_sel_i,
  input  logic             ref_sel_i,
  input  logic [INC_W-1:0] rec_inc_i,
  output logic             win_done_o,
  output logic             in_tol_o
);
  localparam int unsigned CW = WIN_LOG2 + INC_W + 1;

  logic [WIN_LOG2-1:0] win_cnt_q;
  logic [CW-1:0]       acc_q, sum, exp_c, tol_c, diff;
  logic [CW-1:0]       exp_tab [8];
  logic [CW-1:0]       tol_tab [8];

  for (genvar g = 0; g < 8; g++) begin : g_tab
    localparam longint EXP = cdr_sup_pkg::expected_count(WIN_LOG2, g % 4, g / 4);
    assign exp_tab[g] = CW'(EXP);
    assign tol_tab[g] = CW'(EXP / 2000);
  end

  assign exp_c      = exp_tab[{ref_sel_i, rate_sel_i}];
  assign tol_c      = tol_tab[{ref_sel_i, rate_sel_i}];
  assign sum        = acc_q + CW'(rec_inc_i);
  assign diff       = (sum >= exp_c) ? sum - exp_c : exp_c - sum;
  assign win_done_o = !clr_i && (&win_cnt_q);
  assign in_tol_o   = (diff <= tol_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      acc_q     <= '0;
    end else if (clr_i) begin
      win_cnt_q <= '0;
      acc_q     <= '0;
    end else begin
      win_cnt_q <= win_cnt_q + 1'b1;
      acc_q     <= (&win_cnt_q) ? '0 : sum;
    end
  end
endmodule

// File: rtl/cdr_lock_fsm.sv
module cdr_lock_fsm
  import cdr_sup_pkg::*;
#(
  parameter int unsigned LOCK_WIN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic win_done_i,
  input  logic in_tol_i,
  input  logic los_i,
  output logic track_o
);
  localparam int unsigned GW = (LOCK_WIN > 1) ? $clog2(LOCK_WIN) : 1;
  localparam logic [GW-1:0] GOOD_MAX = GW'(LOCK_WIN - 1);

  cdr_state_e    st_q;
  logic [GW-1:0] good_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_REF;
      good_q <= '0;
    end else if (pd_i) begin
      st_q   <= ST_REF;
      good_q <= '0;
    end else begin
      unique case (st_q)
        ST_REF: if (win_done_i) begin
          if (!in_tol_i) begin
            good_q <= '0;
          end else if (good_q == GOOD_MAX && !los_i) begin
            st_q   <= ST_TRACK;
            good_q <= '0;
          end else if (good_q != GOOD_MAX) begin
            good_q <= good_q + 1'b1;
          end
          // count saturates while signal is missing
        end
        ST_TRACK: if (los_i || (win_done_i && !in_tol_i)) begin
          st_q   <= ST_REF;
          good_q <= '0;
        end
      endcase
    end
  end

  assign track_o = (st_q == ST_TRACK);
endmodule

// File: rtl/cdr_lock_supervisor.sv
module cdr_lock_supervisor #(
  parameter int unsigned WIN_LOG2 = 15,
  parameter int unsigned INC_W    = 7,
  parameter int unsigned LOCK_WIN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] rec_inc_i,
  input  logic [1:0]       rate_sel_i,
  input  logic             ref_sel_i,
  input  logic             sd_i,
  input  logic             dlos_i,
  input  logic             dlos_dis_i,
  input  logic             pd_i,
  input  logic             data_i,
  output logic             loop_sel_o,
  output logic             lol_o,
  output logic             data_o
);
  logic sd_s, los, win_done, in_tol, track;

  cdr_sync2 u_sd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sd_i),
    .q_o   (sd_s)
  );

  assign los = !sd_s || (dlos_i && !dlos_dis_i);

  cdr_freq_meter #(
    .WIN_LOG2(WIN_LOG2),
    .INC_W   (INC_W)
  ) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (pd_i),
    .rate_sel_i(rate_sel_i),
    .ref_sel_i (ref_sel_i),
    .rec_inc_i (rec_inc_i),
    .win_done_o(win_done),
    .in_tol_o  (in_tol)
  );

  cdr_lock_fsm #(
    .LOCK_WIN(LOCK_WIN)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pd_i      (pd_i),
    .win_done_i(win_done),
    .in_tol_i  (in_tol),
    .los_i     (los),
    .track_o   (track)
  );

  assign loop_sel_o = track;
  assign lol_o      = !track;
  assign data_o     = data_i && !los && !pd_i;
endmodule

// File: rtl/cdr_lock_chk.sv
module cdr_lock_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sd_i,
  input logic dlos_i,
  input logic dlos_dis_i,
  input logic pd_i,
  input logic data_o,
  input logic loop_sel_o,
  input logic lol_o,
  input logic win_done,
  input logic in_tol,
  input logic los
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 1'b1;
  end

  AST_SD_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && !$past(sd_i, 2)) |-> !data_o); // R5
  AST_DLOS_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlos_i && !dlos_dis_i) |-> !data_o); // R5
  AST_LOS_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_sel_o && los && !pd_i) |=> !loop_sel_o); // R6
  AST_OOT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_sel_o && win_done && !in_tol) |=> (!loop_sel_o && lol_o)); // R4
  AST_ENTER_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && $rose(loop_sel_o)) |-> $past(win_done && in_tol && !los && !pd_i)); // R3
  AST_PD_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (!loop_sel_o && lol_o)); // R10
endmodule

bind cdr_lock_supervisor cdr_lock_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sd_i      (sd_i),
  .dlos_i    (dlos_i),
  .dlos_dis_i(dlos_dis_i),
  .pd_i      (pd_i),
  .data_o    (data_o),
  .loop_sel_o(loop_sel_o),
  .lol_o     (lol_o),
  .win_done  (win_done),
  .in_tol    (in_tol),
  .los       (los)
);

// File: tb/tb_cdr_lock_supervisor.sv
`timescale 1ns/1ps
module tb_cdr_lock_supervisor;
  localparam int WL  = 11;
  localparam int WIN = 1 << WL;
  localparam int IW  = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [IW-1:0] rec_inc = '0;
  logic [1:0] rate_sel = 2'd0;
  logic ref_sel = 1'b0;
  logic sd = 1'b1, dlos = 1'b0, dlos_dis = 1'b0, pd = 1'b0, data_in = 1'b1;
  logic loop_sel, lol, data_out;

  int checks = 0, bad = 0, ph = 0, total = 0;

  always #4 clk = ~clk;

  cdr_lock_supervisor #(.WIN_LOG2(WL), .INC_W(IW), .LOCK_WIN(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rec_inc_i(rec_inc), .rate_sel_i(rate_sel),
    .ref_sel_i(ref_sel), .sd_i(sd), .dlos_i(dlos), .dlos_dis_i(dlos_dis),
    .pd_i(pd), .data_i(data_in), .loop_sel_o(loop_sel), .lol_o(lol), .data_o(data_out)
  );

  function automatic int expc(int r, int f);
    int ru, rf;
    ru = (r == 0) ? 96 : (r == 1) ? 24 : 8;
    rf = f ? 12 : 3;
    return (WIN * ru + rf / 2) / rf;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one reference cycle: drive increment, pass edge, settle
  task automatic step();
    rec_inc = IW'(total / WIN + ((ph < total % WIN) ? 1 : 0));
    @(posedge clk);
    #1;
    ph = (ph + 1) % WIN;
  endtask

  task automatic window(int tot);
    total = tot;
    repeat (WIN) step();
  endtask

  task automatic finish_window();
    while (ph != 0) step();
  endtask

  task automatic restart(int r, int f);
    pd = 1'b1;
    step();
    rate_sel = 2'(r);
    ref_sel = f[0];
    pd = 1'b0;
    ph = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int e0, t0;
    e0 = expc(0, 0);
    t0 = e0 / 2000;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 loop_sel in reset", loop_sel, 0);
    chk("R1 lol in reset", lol, 1);
    chk("R1 data in reset", data_out, 0);
    rst_ni = 1'b1;
    ph = 0;
    total = e0;
    step();
    chk("R5 data muted one edge after reset", data_out, 0);
    step();
    chk("R5 data follows after sync", data_out, 1);
    repeat (WIN - 2) step();
    chk("R3 one good window keeps ref", loop_sel, 0);
    window(e0);
    chk("R3 two good windows -> track", loop_sel, 1);
    chk("R9 lol low while tracking", lol, 0);

    window(e0 + t0);
    chk("R11 upper bound inside", loop_sel, 1);
    window(e0 - t0);
    chk("R11 lower bound inside", loop_sel, 1);
    window(e0 + t0 + 1);
    chk("R4 out of tolerance -> ref", loop_sel, 0);
    chk("R4 lol asserted", lol, 1);

    window(e0);
    window(e0 - t0 - 1);
    window(e0);
    chk("R3 bad window restarts count", loop_sel, 0);
    window(e0);
    chk("R3 relock after two good", loop_sel, 1);

    // data-loss flag while tracking
    total = e0;
    repeat (5) step();
    dlos = 1'b1;
    #1;
    chk("R5 dlos mutes same cycle", data_out, 0);
    step();
    chk("R6 dlos drops loop", loop_sel, 0);
    chk("R9 lol with loss of signal", lol, 1);
    dlos = 1'b0;
    finish_window();
    chk("R3 partial window counts one", loop_sel, 0);
    window(e0);
    chk("R3 relock after dlos", loop_sel, 1);

    // masked flag
    dlos_dis = 1'b1;
    dlos = 1'b1;
    #1;
    chk("R8 masked dlos data passes", data_out, 1);
    step();
    chk("R8 masked dlos keeps track", loop_sel, 1);
    finish_window();
    chk("R8 masked dlos window end", loop_sel, 1);
    dlos = 1'b0;
    dlos_dis = 1'b0;

    // signal detect drop
    sd = 1'b0;
    step();
    chk("R5 sd first edge data", data_out, 1);
    step();
    chk("R5 sd second edge muted", data_out, 0);
    chk("R6 loop still tracking", loop_sel, 1);
    step();
    chk("R6 sd drop -> ref", loop_sel, 0);
    finish_window();
    window(e0);
    chk("R7 held on ref under los", loop_sel, 0);
    chk("R5 data muted for los duration", data_out, 0);
    sd = 1'b1;
    window(e0);
    chk("R7 reacquire after los clears", loop_sel, 1);
    chk("R5 data restored", data_out, 1);

    // power down
    total = e0;
    repeat (3) step();
    pd = 1'b1;
    #1;
    chk("R10 pd mutes data", data_out, 0);
    step();
    chk("R10 pd forces ref", loop_sel, 0);
    chk("R10 pd asserts lol", lol, 1);

    // rate / reference sweep
    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < 4; r++) begin
        int e, t;
        e = expc(r, f);
        t = e / 2000;
        restart(r, f);
        window(e - t);
        chk($sformatf("R2 r%0d f%0d first window", r, f), loop_sel, 0);
        window(e + t);
        chk($sformatf("R11 r%0d f%0d bounds lock", r, f), loop_sel, 1);
        window(e - t - 1);
        chk($sformatf("R11 r%0d f%0d below bound", r, f), loop_sel, 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule